// File: doc/BRIEF.md
# Dual-Clock Mailbox Pair

This block gives two ports that run on unrelated clocks a narrow side channel for control and status words. It is separate from any bulk data queue. It holds one 36-bit word per direction. Port A posts words that port B collects, and port B posts words that port A collects. Each receiving side has a new-mail indicator that is generated in its own clock domain.

A write strobe on the sending side latches the word and toggles a request bit. On the receiving side, a two-stage synchronizer passes that bit across, and a detected change raises the new-mail indicator. The receiver takes the word by pulsing its read strobe while the indicator is high. That read clears the indicator and toggles an acknowledge bit back toward the sender. After synchronization, the acknowledge appears as a one-cycle "taken" pulse in the sender's domain.

A single active-low reset input is asserted asynchronously. Each clock domain releases it synchronously.

Top module: `dual_mailbox`

## Requirements
- R1: While reset is held and just after it is released, both new-mail indicators are 0, both read-data buses read 0, and no taken pulse appears.
- R2: A write strobe on port A stores the word for port B. Port B's new-mail indicator goes to 1 no earlier than the third and no later than the fourth rising edge of port B's clock after the write edge. From then on, port B's read data equals the written word. Port A's own new-mail indicator does not change.
- R3: A write strobe on port B behaves the same way toward port A, with the two ports' roles swapped.
- R4: A read strobe that is sampled while the new-mail indicator is 1 makes the indicator 0 after that same clock edge. The exception is when a newer word arrives in that same cycle.
- R5: A read strobe that is sampled while the new-mail indicator is 0 has no effect. The indicator stays 0, and the sender sees no taken pulse.
- R6: A second write before the receiver reads replaces the stored word and leaves the indicator at 1. One read then clears the indicator, it does not rise again, and exactly one taken pulse results.
- R7: Each read that clears an indicator produces exactly one taken pulse on the sending port. The pulse is one sender clock cycle long and arrives within eight sender cycles.
- R8: A stored word changes only on a write strobe of its sending port. Reads leave the receiver's read data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_clk | input | 1 | Port A clock |
| a_put | input | 1 | Port A write strobe into the A-to-B mailbox |
| a_put_data | input | 36 | Word written by port A |
| a_get | input | 1 | Port A read strobe for the B-to-A mailbox |
| a_get_data | output | 36 | Word currently held in the B-to-A mailbox |
| a_new_mail | output | 1 | B-to-A mailbox holds an unread word (port A domain) |
| a_taken | output | 1 | One-cycle pulse: port B has read the A-to-B word |
| b_clk | input | 1 | Port B clock |
| b_put | input | 1 | Port B write strobe into the B-to-A mailbox |
| b_put_data | input | 36 | Word written by port B |
| b_get | input | 1 | Port B read strobe for the A-to-B mailbox |
| b_get_data | output | 36 | Word currently held in the A-to-B mailbox |
| b_new_mail | output | 1 | A-to-B mailbox holds an unread word (port B domain) |
| b_taken | output | 1 | One-cycle pulse: port A has read the B-to-A word |

## Verification
The assertions assume that two writes into the same mailbox are far enough apart for the receiver to see every request toggle, at least three receiver clock periods. They also assume the sender does not rewrite a word while the receiver is sampling it. In addition, the taken-pulse check assumes that two reads of one mailbox are spaced so that the acknowledge toggles arrive one at a time. The stimulus stays within these limits: it waits six receiver cycles after every write and eight sender cycles after every read before the next access. It sweeps a walking bit, with alternating nibbles overlaid, across all 36 bit positions in both directions.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_WIDTH   = 36;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RST_STAGES  = 2;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = mbx_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) shift_q <= '0;
    else           shift_q <= shift_d;
  end

  assign rst_out_n = shift_q[STAGES-1];
endmodule

// File: rtl/mbx_bit_sync.sv
module mbx_bit_sync #(
  parameter int unsigned STAGES = mbx_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
// One direction: a word register in the sender domain, a new-mail flag in
// the receiver domain, and a toggle handshake between the two.
module mbx_channel #(
  parameter int unsigned W      = mbx_pkg::MBX_WIDTH,
  parameter int unsigned STAGES = mbx_pkg::SYNC_STAGES
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         put,
  input  logic [W-1:0] put_data,
  output logic         taken,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         get,
  output logic [W-1:0] get_data,
  output logic         new_mail
);
  // ---------------- sender domain ----------------
  logic [W-1:0] word_q, word_d;
  logic         req_q, req_d;
  logic         ack_s;
  logic         ack_seen_q, ack_seen_d;
  logic         taken_q, taken_d;

  // ---------------- receiver domain --------------
  logic req_s;
  logic req_seen_q, req_seen_d;
  logic flag_q, flag_d;
  logic ack_q, ack_d;
  logic arrive;
  logic take;

  mbx_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(wclk), .rst_n(wrst_n), .d(ack_q), .q(ack_s)
  );

  always_comb begin
    word_d     = put ? put_data : word_q;
    req_d      = req_q ^ put;
    ack_seen_d = ack_s;
    taken_d    = ack_s ^ ack_seen_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      word_q     <= '0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      taken_q    <= 1'b0;
    end else begin
      if (put) word_q <= word_d;
      req_q      <= req_d;
      ack_seen_q <= ack_seen_d;
      taken_q    <= taken_d;
    end
  end

  mbx_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(rclk), .rst_n(rrst_n), .d(req_q), .q(req_s)
  );

  always_comb begin
    arrive     = req_s ^ req_seen_q;
    take       = get & flag_q;
    flag_d     = arrive | (flag_q & ~get);
    ack_d      = ack_q ^ take;
    req_seen_d = req_s;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      req_seen_q <= 1'b0;
      flag_q     <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      req_seen_q <= req_seen_d;
      flag_q     <= flag_d;
      ack_q      <= ack_d;
    end
  end

  // The word is quasi-static: it settles before the flag can rise.
  assign get_data = word_q;
  assign new_mail = flag_q;
  assign taken    = taken_q;

  // R8: stored word moves only with a write strobe
  p_word_hold_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    !put |=> $stable(word_q));

  // R7: acknowledge becomes a single-cycle pulse
  p_taken_single_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
    taken_q |=> !taken_q);

  // R2 and R3: the flag only rises on a synchronized request change
  p_rise_on_arrival_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(flag_q) |-> $past(req_s != req_seen_q));

  // R4: a read of pending mail clears it unless new mail lands together
  p_clear_on_get_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (get && flag_q && !arrive) |=> !flag_q);

  // R5: a read with nothing pending sends no acknowledge
  p_idle_get_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    (get && !flag_q) |=> $stable(ack_q));

  // R6: pending mail stays flagged until it is read
  p_flag_hold_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (flag_q && !get) |=> flag_q);
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox #(
  parameter int unsigned W = mbx_pkg::MBX_WIDTH
) (
  input  logic         rst_n,
  input  logic         a_clk,
  input  logic         a_put,
  input  logic [W-1:0] a_put_data,
  input  logic         a_get,
  output logic [W-1:0] a_get_data,
  output logic         a_new_mail,
  output logic         a_taken,
  input  logic         b_clk,
  input  logic         b_put,
  input  logic [W-1:0] b_put_data,
  input  logic         b_get,
  output logic [W-1:0] b_get_data,
  output logic         b_new_mail,
  output logic         b_taken
);
  logic a_rst_n;
  logic b_rst_n;

  mbx_rst_sync u_rst_a (.clk(a_clk), .rst_in_n(rst_n), .rst_out_n(a_rst_n));
  mbx_rst_sync u_rst_b (.clk(b_clk), .rst_in_n(rst_n), .rst_out_n(b_rst_n));

  // A writes, B reads
  mbx_channel #(.W(W)) u_a2b (
    .wclk(a_clk), .wrst_n(a_rst_n), .put(a_put), .put_data(a_put_data),
    .taken(a_taken),
    .rclk(b_clk), .rrst_n(b_rst_n), .get(b_get), .get_data(b_get_data),
    .new_mail(b_new_mail)
  );

  // B writes, A reads
  mbx_channel #(.W(W)) u_b2a (
    .wclk(b_clk), .wrst_n(b_rst_n), .put(b_put), .put_data(b_put_data),
    .taken(b_taken),
    .rclk(a_clk), .rrst_n(a_rst_n), .get(a_get), .get_data(a_get_data),
    .new_mail(a_new_mail)
  );
endmodule

// File: tb/sim_dual_mailbox.sv
module sim_dual_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int B_HALF     = 7;
  localparam int WD_LIMIT   = 150000;

  logic        rst_n = 1'b0;
  logic        a_clk = 1'b0;
  logic        b_clk = 1'b0;
  logic        a_put = 1'b0, b_put = 1'b0, a_get = 1'b0, b_get = 1'b0;
  logic [35:0] a_put_data = '0, b_put_data = '0;
  logic [35:0] a_get_data, b_get_data;
  logic        a_new_mail, b_new_mail, a_taken, b_taken;

  int checks = 0;
  int fails  = 0;
  int a_taken_cnt = 0;
  int b_taken_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) a_clk = ~a_clk;
  always #(B_HALF)       b_clk = ~b_clk;

  dual_mailbox u0 (
    .rst_n(rst_n),
    .a_clk(a_clk), .a_put(a_put), .a_put_data(a_put_data), .a_get(a_get),
    .a_get_data(a_get_data), .a_new_mail(a_new_mail), .a_taken(a_taken),
    .b_clk(b_clk), .b_put(b_put), .b_put_data(b_put_data), .b_get(b_get),
    .b_get_data(b_get_data), .b_new_mail(b_new_mail), .b_taken(b_taken)
  );

  always @(negedge a_clk) if (a_taken) a_taken_cnt = a_taken_cnt + 1;
  always @(negedge b_clk) if (b_taken) b_taken_cnt = b_taken_cnt + 1;

  task automatic chk(input logic [35:0] got, input logic [35:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(negedge a_clk);
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(negedge b_clk);
  endtask

  task automatic put_a(input logic [35:0] v);
    @(negedge a_clk); a_put = 1'b1; a_put_data = v;
    @(negedge a_clk); a_put = 1'b0;
  endtask

  task automatic put_b(input logic [35:0] v);
    @(negedge b_clk); b_put = 1'b1; b_put_data = v;
    @(negedge b_clk); b_put = 1'b0;
  endtask

  task automatic get_a();
    @(negedge a_clk); a_get = 1'b1;
    @(negedge a_clk); a_get = 1'b0;
  endtask

  task automatic get_b();
    @(negedge b_clk); b_get = 1'b1;
    @(negedge b_clk); b_get = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge a_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish got=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int base_a;
    int base_b;
    logic [35:0] p;
    wait_a(3);
    // R1: state during reset
    chk({35'd0, a_new_mail}, 36'd0, "R1 a_new_mail in reset");
    chk({35'd0, b_new_mail}, 36'd0, "R1 b_new_mail in reset");
    chk(a_get_data, 36'd0, "R1 a_get_data in reset");
    chk(b_get_data, 36'd0, "R1 b_get_data in reset");
    rst_n = 1'b1;
    wait_a(6);
    wait_b(6);
    chk({35'd0, a_new_mail}, 36'd0, "R1 a_new_mail after reset");
    chk({35'd0, b_new_mail}, 36'd0, "R1 b_new_mail after reset");
    chk(a_taken_cnt, 0, "R1 no a_taken pulse");
    chk(b_taken_cnt, 0, "R1 no b_taken pulse");

    // R5: reads with no mail pending
    get_b(); wait_b(1);
    get_a(); wait_a(1);
    wait_a(8); wait_b(8);
    chk({35'd0, b_new_mail}, 36'd0, "R5 b_new_mail after idle read");
    chk({35'd0, a_new_mail}, 36'd0, "R5 a_new_mail after idle read");
    chk(a_taken_cnt, 0, "R5 no a_taken after idle read");
    chk(b_taken_cnt, 0, "R5 no b_taken after idle read");

    for (int i = 0; i < 36; i++) begin
      p = (36'd1 << i) ^ (((i % 2) == 1) ? 36'hF0F0F0F0F : 36'h0);
      // R2: A to B
      base_a = a_taken_cnt;
      put_a(p);
      chk({35'd0, b_new_mail}, 36'd0, "R2 flag not before sync latency");
      wait_b(6);
      chk({35'd0, b_new_mail}, 36'd1, "R2 b_new_mail raised");
      chk(b_get_data, p, "R2 b_get_data word");
      chk({35'd0, a_new_mail}, 36'd0, "R2 a_new_mail untouched");
      get_b();
      chk({35'd0, b_new_mail}, 36'd0, "R4 b_new_mail cleared by read");
      chk(b_get_data, p, "R8 b_get_data held after read");
      wait_a(8);
      chk(a_taken_cnt - base_a, 1, "R7 one a_taken pulse");

      // R3: B to A
      base_b = b_taken_cnt;
      put_b(~p);
      wait_a(6);
      chk({35'd0, a_new_mail}, 36'd1, "R3 a_new_mail raised");
      chk(a_get_data, ~p, "R3 a_get_data word");
      chk({35'd0, b_new_mail}, 36'd0, "R3 b_new_mail untouched");
      get_a();
      chk({35'd0, a_new_mail}, 36'd0, "R4 a_new_mail cleared by read");
      chk(a_get_data, ~p, "R8 a_get_data held after read");
      wait_b(8);
      chk(b_taken_cnt - base_b, 1, "R7 one b_taken pulse");
      chk(b_get_data, p, "R8 b_get_data unchanged by B to A traffic");
    end

    // R6: overwrite before read
    base_a = a_taken_cnt;
    put_a(36'h123456789);
    wait_b(6);
    put_a(36'hABCDEF012);
    wait_b(6);
    chk({35'd0, b_new_mail}, 36'd1, "R6 flag still set after overwrite");
    chk(b_get_data, 36'hABCDEF012, "R6 newest word visible");
    get_b();
    wait_b(10);
    chk({35'd0, b_new_mail}, 36'd0, "R6 flag stays clear after one read");
    wait_a(8);
    chk(a_taken_cnt - base_a, 1, "R6 exactly one a_taken pulse");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule